// File: doc/BRIEF.md
# Predicated Tree Reduction Scheduler

This block reduces a short vector of element values to one value with a fixed pairwise tree. A caller presents the element values, a vector length and a per-lane predicate, picks one of four combine operations and pulses `start`. The block captures everything into an internal buffer and then runs one tree stage per clock. In each stage, lanes that sit on a multiple of the current stride absorb the lane half a stride above them. The stride starts at 2 and doubles each stage.

Masked-out lanes are never fed to the operation. If only the upper partner of a pair is live, the lower lane takes a copy of it. If only the lower lane is live, it keeps its value. The lower lane's predicate then records that something live now sits there. Because of this, the final value always ends up in lane 0, whose predicate is set exactly when at least one lane was live. The pairing order depends only on the vector length, so a given input always gives the same result. The whole buffer and predicate stay visible after completion, so intermediate per-stage values can be inspected.

Top module: `tree_reduce_top`

## Requirements
- R1: After reset `busy`, `done` and `result_valid` are 0 and `pred_out` and `elems_out` are 0. A `start` while not busy captures `data_in`, `op` and `vl`, and captures `pred_in` with every lane at index `vl` or above cleared.
- R2: With S = ceil(log2(vl)), `done` pulses for one cycle exactly S clock edges after the edge that captured `start`. `busy` is high during the S stage cycles and low when `done` is high.
- R3: Stage k (k = 0..S-1) uses half = 2^k. Every lane i that is a multiple of 2*half, and has i+half below `vl`, pairs with lane i+half. When both are live, lane i becomes op(lane i, lane i+half), with lane i as the left operand.
- R4: When only lane i+half is live, lane i takes its value. When lane i+half is dead, lane i keeps its value.
- R5: After each pairing, the predicate of lane i becomes its old value ORed with the partner's predicate. Predicate bits only ever rise during a reduction.
- R6: The `op` encoding is 2'b00 add modulo 2^DATA_W, 2'b01 bitwise OR, 2'b10 unsigned minimum, and 2'b11 unsigned maximum.
- R7: `result` shows lane 0 of the buffer. `result_valid` is high only in the `done` cycle, and only if lane 0's final predicate is set. If no lane below `vl` was live, `result_valid` stays 0.
- R8: With `vl` = 1, lane 0 is returned unchanged and `done` pulses one edge after capture, with no stage run.
- R9: Data and predicate of lanes at index `vl` or above never affect the result or the predicate of lanes below `vl`.
- R10: A `start` raised while `busy` is high is ignored, and the running reduction completes with its original operands.
- R11: After `done`, `elems_out` holds the full per-lane buffer, including intermediate partial results. `elems_out` and `pred_out` do not change until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and begin a reduction |
| vl | input | VL_W (4) | Vector length, 0..MAX_VL |
| op | input | 2 | Combine operation selector |
| pred_in | input | MAX_VL (8) | Per-lane predicate, bit i for lane i |
| data_in | input | MAX_VL*DATA_W (128) | Lane values, lane i at bits i*DATA_W upward |
| busy | output | 1 | Tree stages in progress |
| done | output | 1 | One-cycle completion pulse |
| result_valid | output | 1 | Result is meaningful (pulses with done) |
| result | output | DATA_W (16) | Reduced value (lane 0) |
| pred_out | output | MAX_VL (8) | Current per-lane predicate |
| elems_out | output | MAX_VL*DATA_W (128) | Current per-lane buffer contents |

## Verification
On every cycle, the assertions check the following. `done` never overlaps `busy`. The stage index stays inside the tree depth. Predicate bits only rise while stages run. `result_valid` only appears with `done`. The buffer and predicate hold still while idle. A length-one request completes on the next edge. Only the bench's scenarios can show whether the values are right: the combine order, the copy of a lone live partner, the lanes beyond `vl` being ignored, the all-masked case, a `start` during a run being rejected, and the exact latency of ceil(log2(vl)) for each length. All of these are compared against an independent model of the tree for the result, `pred_out` and the full buffer.

// File: rtl/tree_reduce_pkg.sv
package tree_reduce_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_OR  = 2'b01,
    OP_MIN = 2'b10,
    OP_MAX = 2'b11
  } red_op_e;

  // Number of halving stages needed to fold n lanes into one.
  function automatic int ceil_log2(input int n);
    int r;
    r = 0;
    for (int k = 0; k < 31; k++) begin
      if ((1 << k) < n) r = k + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/tree_reduce_stage.sv
module tree_reduce_stage
  import tree_reduce_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 8,
  parameter int HALF   = 1
) (
  input  red_op_e                        op,
  input  logic [LANES-1:0][DATA_W-1:0]   vals_i,
  input  logic [LANES-1:0]               pred_i,
  output logic [LANES-1:0][DATA_W-1:0]   vals_o,
  output logic [LANES-1:0]               pred_o
);

  localparam int STRIDE = 2 * HALF;

  function automatic logic [DATA_W-1:0] combine(input red_op_e o,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    case (o)
      OP_ADD:  return a + b;
      OP_OR:   return a | b;
      OP_MIN:  return (a < b) ? a : b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if ((i % STRIDE == 0) && (i + HALF < LANES)) begin : g_pair
      logic own_live, mate_live;
      assign own_live  = pred_i[i];
      assign mate_live = pred_i[i+HALF];
      assign vals_o[i] = !mate_live ? vals_i[i] :
                         (own_live ? combine(op, vals_i[i], vals_i[i+HALF])
                                   : vals_i[i+HALF]);
      assign pred_o[i] = own_live | mate_live;
    end else begin : g_pass
      assign vals_o[i] = vals_i[i];
      assign pred_o[i] = pred_i[i];
    end
  end

endmodule

// File: rtl/tree_reduce_ctrl.sv
module tree_reduce_ctrl
  import tree_reduce_pkg::*;
#(
  parameter int VL_W  = 4,
  parameter int LVLS  = 3,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VL_W-1:0]  vl,
  output logic             busy,
  output logic             done,
  output logic             load_en,
  output logic             step_en,
  output logic [LVL_W-1:0] lvl
);

  logic [LVL_W-1:0] last_lvl;
  logic [LVL_W-1:0] need;
  int               need_i;

  assign load_en = start && !busy;
  assign step_en = busy;

  always_comb begin
    need_i = ceil_log2(int'(vl));
    if (need_i > LVLS) need_i = LVLS;
    need = LVL_W'(need_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      lvl      <= '0;
      last_lvl <= '0;
    end else begin
      done <= 1'b0;
      if (load_en) begin
        lvl      <= '0;
        last_lvl <= need - LVL_W'(1);
        if (need == '0) done <= 1'b1;
        else            busy <= 1'b1;
      end else if (busy) begin
        lvl <= lvl + LVL_W'(1);
        if (lvl == last_lvl) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_LVL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(lvl) < LVLS)) else $error("stage index out of range"); // R2
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (vl <= VL_W'(1))) |=> (done && !busy))
    else $error("short vector did not finish at once"); // R8

endmodule

// File: rtl/tree_reduce_top.sv
module tree_reduce_top
  import tree_reduce_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_VL = 8,
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [VL_W-1:0]            vl,
  input  logic [1:0]                 op,
  input  logic [MAX_VL-1:0]          pred_in,
  input  logic [MAX_VL*DATA_W-1:0]   data_in,
  output logic                       busy,
  output logic                       done,
  output logic                       result_valid,
  output logic [DATA_W-1:0]          result,
  output logic [MAX_VL-1:0]          pred_out,
  output logic [MAX_VL*DATA_W-1:0]   elems_out
);

  localparam int LVLS  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;
  localparam int LVL_W = $clog2(LVLS + 1);

  typedef logic [MAX_VL-1:0][DATA_W-1:0] lanes_t;

  lanes_t              buf_v, din_v, nxt_v;
  logic [MAX_VL-1:0]   buf_p, nxt_p, lane_in_len;
  red_op_e             op_q;
  logic                load_en, step_en;
  logic [LVL_W-1:0]    lvl;

  lanes_t              stg_v [LVLS];
  logic [MAX_VL-1:0]   stg_p [LVLS];

  assign din_v = data_in;

  always_comb begin
    for (int i = 0; i < MAX_VL; i++) lane_in_len[i] = (i < int'(vl));
  end

  tree_reduce_ctrl #(.VL_W(VL_W), .LVLS(LVLS), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .busy(busy), .done(done), .load_en(load_en), .step_en(step_en), .lvl(lvl)
  );

  for (genvar g = 0; g < LVLS; g++) begin : g_stage
    tree_reduce_stage #(.DATA_W(DATA_W), .LANES(MAX_VL), .HALF(1 << g)) u_stg (
      .op(op_q), .vals_i(buf_v), .pred_i(buf_p),
      .vals_o(stg_v[g]), .pred_o(stg_p[g])
    );
  end

  always_comb begin
    nxt_v = buf_v;
    nxt_p = buf_p;
    for (int g = 0; g < LVLS; g++) begin
      if (lvl == LVL_W'(g)) begin
        nxt_v = stg_v[g];
        nxt_p = stg_p[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_v <= '0;
      buf_p <= '0;
      op_q  <= OP_ADD;
    end else if (load_en) begin
      buf_v <= din_v;
      buf_p <= pred_in & lane_in_len;
      op_q  <= red_op_e'(op);
    end else if (step_en) begin
      buf_v <= nxt_v;
      buf_p <= nxt_p;
    end
  end

  assign elems_out    = buf_v;
  assign pred_out     = buf_p;
  assign result       = buf_v[0];
  assign result_valid = done && buf_p[0];

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R2
  AST_PRED_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((pred_out & $past(pred_out)) == $past(pred_out)))
    else $error("predicate bit fell during stages"); // R5
  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> done) else $error("valid without done"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(elems_out) && $stable(pred_out)))
    else $error("buffer moved while idle"); // R11

endmodule

// File: tb/tree_reduce_top_tb.sv
module tree_reduce_top_tb;

  localparam int DW = 16;
  localparam int NL = 8;

  typedef struct {
    int              scyc;
    int              stages;
    logic [DW-1:0]   res;
    logic            vld;
    logic [NL-1:0]   pred;
    logic [NL*DW-1:0] elems;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] vl = '0;
  logic [1:0] op = '0;
  logic [NL-1:0] pred_in = '0;
  logic [NL*DW-1:0] data_in = '0;
  logic busy, done, result_valid;
  logic [DW-1:0] result;
  logic [NL-1:0] pred_out;
  logic [NL*DW-1:0] elems_out;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tree_reduce_top #(.DATA_W(DW), .MAX_VL(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .op(op),
    .pred_in(pred_in), .data_in(data_in), .busy(busy), .done(done),
    .result_valid(result_valid), .result(result), .pred_out(pred_out),
    .elems_out(elems_out)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [NL*DW-1:0] act, input logic [NL*DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] f_op(input logic [1:0] o,
                                         input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW:0] s;
    case (o)
      2'd0: begin s = {1'b0, x} + {1'b0, y}; return s[DW-1:0]; end
      2'd1: return x | y;
      2'd2: return (y < x) ? y : x;
      default: return (y > x) ? y : x;
    endcase
  endfunction

  function automatic exp_t model(input int n, input logic [1:0] o,
                                 input logic [NL-1:0] p_in, input logic [NL*DW-1:0] d_in);
    exp_t e;
    logic [DW-1:0] v [NL];
    logic [NL-1:0] p;
    for (int i = 0; i < NL; i++) begin
      v[i] = d_in[i*DW +: DW];
      p[i] = p_in[i] && (i < n);
    end
    e.stages = 0;
    for (int h = 1; h < n; h = h * 2) begin
      e.stages++;
      for (int i = 0; i + h < n; i = i + 2 * h) begin
        if (p[i+h]) begin
          v[i] = p[i] ? f_op(o, v[i], v[i+h]) : v[i+h];
          p[i] = 1'b1;
        end
      end
    end
    for (int i = 0; i < NL; i++) e.elems[i*DW +: DW] = v[i];
    e.pred = p;
    e.res  = v[0];
    e.vld  = p[0];
    e.scyc = 0;
    e.tag  = "";
    return e;
  endfunction

  // Driver: launch one reduction, optionally poke start again while busy.
  task automatic run_op(input int n, input logic [1:0] o, input logic [NL-1:0] p,
                        input logic [NL*DW-1:0] d, input string tag, input bit poke);
    exp_t e;
    @(negedge clk);
    vl = 4'(n); op = o; pred_in = p; data_in = d; start = 1'b1;
    e = model(n, o, p, d);
    e.tag = tag;
    @(posedge clk);
    e.scyc = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    if (poke) begin
      // R10: new operands presented while busy must be ignored
      vl = 4'd1; op = 2'd3; pred_in = '1; data_in = {NL{16'h7777}};
      @(negedge clk);
    end
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compare each completion against the queued expectation.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.scyc + e.stages, {e.tag, " R2 latency"}, cyc - e.scyc, e.stages);
        chk(busy == 1'b0, {e.tag, " R2 busy low at done"}, busy, 0);
        chk(result === e.res, {e.tag, " R3/R6 result"}, result, e.res);
        chk(result_valid === e.vld, {e.tag, " R7 result_valid"}, result_valid, e.vld);
        chk(pred_out === e.pred, {e.tag, " R5 pred_out"}, pred_out, e.pred);
        chk(elems_out === e.elems, {e.tag, " R4/R11 elems_out"}, elems_out, e.elems);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [NL*DW-1:0] snap_e;
    logic [NL-1:0] snap_p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && result_valid == 0, "R1 reset flags", {busy, done, result_valid}, 0);
    chk(pred_out == 0, "R1 reset pred_out", pred_out, 0);
    chk(elems_out == 0, "R1 reset elems_out", elems_out, 0);

    // R3 R6 add, all lanes live, plus wraparound on add
    run_op(8, 2'd0, 8'hFF, {16'd8,16'd7,16'd6,16'd5,16'd4,16'd3,16'd2,16'd1}, "R3 add full", 0);
    run_op(2, 2'd0, 8'h03, {96'h0, 16'h0002, 16'hFFFF}, "R6 add wrap", 0);
    // R6 OR, MIN, MAX with sparse predicates
    run_op(8, 2'd1, 8'hA5, {16'h8000,16'h4000,16'h2000,16'h1000,16'h0800,16'h0400,16'h0200,16'h0100}, "R6 or", 0);
    run_op(8, 2'd2, 8'h5A, {16'd50,16'd3,16'd90,16'd7,16'd1,16'd44,16'd9,16'd2}, "R6 min", 0);
    run_op(7, 2'd3, 8'h7E, {16'd999,16'd3,16'd90,16'd7,16'd1,16'd44,16'd9,16'd2}, "R6 max", 0);
    // R4 only the upper partner live: lane 0 takes a copy
    run_op(2, 2'd0, 8'h02, {96'h0, 16'h00BB, 16'h00AA}, "R4 copy partner", 0);
    run_op(4, 2'd0, 8'h08, {64'h0, 16'h0044, 16'h0033, 16'h0022, 16'h0011}, "R4 copy deep", 0);
    // R7 all masked out
    run_op(8, 2'd0, 8'h00, {8{16'h1234}}, "R7 none live", 0);
    // R8 single lane, live and dead
    run_op(1, 2'd0, 8'hFF, {{7{16'hFFFF}}, 16'h0ABC}, "R8 vl1 live", 0);
    run_op(1, 2'd3, 8'h00, {{7{16'hFFFF}}, 16'h0DEF}, "R8 vl1 dead", 0);
    // R9 lanes beyond vl carry junk with predicate set
    run_op(5, 2'd0, 8'hFF, {16'hFFFF,16'hFFFF,16'hFFFF,16'd5,16'd4,16'd3,16'd2,16'd1}, "R9 vl5", 0);
    run_op(3, 2'd3, 8'hF8, {16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'd3,16'd2,16'd1}, "R9 vl3 dead", 0);
    // R10 start during busy ignored
    run_op(8, 2'd0, 8'hFF, {8{16'd3}}, "R10 start while busy", 1);

    // R11 buffer holds while idle
    snap_e = elems_out; snap_p = pred_out;
    repeat (5) @(negedge clk);
    chk(elems_out === snap_e, "R11 elems hold idle", elems_out, snap_e);
    chk(pred_out === snap_p, "R11 pred hold idle", pred_out, snap_p);

    // Mixed patterns over all lengths and operations
    for (int k = 0; k < 40; k++) begin
      logic [NL*DW-1:0] d;
      for (int i = 0; i < NL; i++) d[i*DW +: DW] = 16'($urandom);
      run_op(1 + (k % NL), 2'(k / NL), 8'($urandom), d, "R3 mixed", 0);
    end

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2 all completions seen", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule